// File: doc/BRIEF.md
# Core-to-Host Packet Mailbox

This block is a register-mapped mailbox between a CPU core and a host processor. It is used for passing network packets, or single bytes, in both directions. Each side has its own byte-wide register port. The core's window holds the following registers:

- a status byte and a control byte;
- 16-bit transmit-unit and receive-unit length limits;
- a 32-bit packet-buffer pointer;
- a size register;
- a one-byte data port.

Above offset 0x100 the core can also reach a shared packet RAM, which the host sees at the same offsets.

Each direction has its own handshake flags. A core-raised "ready" flag stays pending until the host acknowledges it. A host-raised "new data" flag stays set until the core acknowledges it. The acknowledging side's partner sees a one-cycle acknowledge bit. Busy and in-progress flags are plain levels.

A two-bit mode, set through the control byte, selects how the window behaves:

| Mode | Behaviour |
|------|-----------|
| 00 | byte port only |
| 01 | 16-bit pointer buffer |
| 10 | 32-bit pointer buffer |
| 11 | 32-bit with the shared RAM mapped into the window |

The mode gates the length registers, the upper pointer half and the RAM window.

Top module: `pkt_mailbox`

## Requirements
- R1: After synchronous reset every register, flag and read-data output is zero, and the mode is byte mode (00).
- R2: A core write of control (0x01) with bit0=1 sets a pending-send flag, which the host sees at host offset 0x00 bit0. A host write of 0x00 with bit2=1 clears it. Core status (0x00) bit2 then reads 1 only in the cycle right after that acknowledge. A set and a clear in the same cycle leave the flag set.
- R3: A host write of 0x00 with bit0=1 sets core status bit0. A core control write with bit2=1 clears it. Host offset 0x00 bit2 then reads 1 only in the cycle right after that acknowledge. A host set wins over a same-cycle clear.
- R4: Host flag writes at 0x00 load levels: bit1 is busy and bit3 is in-progress. The core sees them at status bits 1 and 3. Control bit1 is the core-busy level, which the host sees at bit1 of its offset 0x00.
- R5: Control bits 7:6 load the mode. Both the core status byte and the host offset 0x00 return the mode in bits 7:6.
- R6: The transmit-unit length is at 0x02 (high byte) and 0x03 (low byte). The receive-unit length is at 0x04 and 0x05. After any byte write, a 16-bit value above 0xFF00 saturates to 0xFF00. In byte mode, writes to these offsets are ignored.
- R7: Pointer bits 15:0 are at 0x06 and 0x07 and are writable in any mode. Pointer bits 31:16 are at 0x08 and 0x09 and are writable only in modes 10 and 11.
- R8: Core writes to 0x0A and 0x0B (high, low) set the outgoing size, which the host reads at 0x02 and 0x03. Core reads of 0x0A and 0x0B return the size the host wrote at its 0x02 and 0x03.
- R9: A core byte written at 0x0F is read by the host at 0x01. A byte the host writes at 0x01 is read by the core at 0x0F.
- R10: In byte mode, a core write to 0x0F while host busy is set is dropped and sets a sticky overrun bit. The bit appears at status bit4 on both sides and is cleared only by a control write with bit4=1.
- R11: Core offsets 0x01, 0x0C to 0x0E and 0x10 to 0xFF read as zero. Writes to 0x00, 0x0C to 0x0E and 0x10 to 0xFF have no effect.
- R12: Core offsets 0x100 up to 0x100+BUF_BYTES-1 access the shared RAM only in mode 11. In other modes they read zero and drop writes. The host reaches the same RAM at the same offsets in every mode. Offsets at or beyond the end read zero. When both sides write one byte in the same cycle, the core's data is kept.
- R13: Read data is registered. It changes on the clock edge after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_addr | input | ADDR_W | Core byte offset |
| c_wr | input | 1 | Core write strobe |
| c_rd | input | 1 | Core read strobe |
| c_wdata | input | 8 | Core write data |
| c_rdata | output | 8 | Core read data, one cycle after c_rd |
| h_addr | input | ADDR_W | Host byte offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, one cycle after h_rd |

## Verification
The bench builds the block with ADDR_W=16 and BUF_BYTES=32.

With that small RAM, filling every byte and probing the first offset past the end take only a few dozen cycles. This makes the end-of-window zero read and the mode-gated drop easy to hit. The same-cycle collision between core and host writes is also cheap to exercise.

The 16-bit address keeps the full reserved range 0x10 to 0xFF reachable. It also lets the length saturation at 0xFF00 be driven from either byte order.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE  = 2'b00,
        MODE_PB16  = 2'b01,
        MODE_PB32  = 2'b10,
        MODE_MAP32 = 2'b11
    } mbx_mode_e;

    // core window offsets
    localparam logic [7:0] C_STATUS = 8'h00;
    localparam logic [7:0] C_CTRL   = 8'h01;
    localparam logic [7:0] C_MTU_H  = 8'h02;
    localparam logic [7:0] C_MTU_L  = 8'h03;
    localparam logic [7:0] C_MRU_H  = 8'h04;
    localparam logic [7:0] C_MRU_L  = 8'h05;
    localparam logic [7:0] C_PTR_H  = 8'h06;
    localparam logic [7:0] C_PTR_L  = 8'h07;
    localparam logic [7:0] C_PTRX_H = 8'h08;
    localparam logic [7:0] C_PTRX_L = 8'h09;
    localparam logic [7:0] C_SIZE_H = 8'h0A;
    localparam logic [7:0] C_SIZE_L = 8'h0B;
    localparam logic [7:0] C_BYTE   = 8'h0F;

    // host window offsets
    localparam logic [7:0] H_FLAGS  = 8'h00;
    localparam logic [7:0] H_BYTE   = 8'h01;
    localparam logic [7:0] H_SIZE_H = 8'h02;
    localparam logic [7:0] H_SIZE_L = 8'h03;

    localparam logic [15:0] LEN_CAP = 16'hFF00;
    localparam int          RAM_BASE = 256;

    // flags the host drives, as the core sees them in status bits 3:0
    typedef struct packed {
        logic rxp;
        logic ack;
        logic bsy;
        logic rx;
    } host_flags_t;

    // flags the core drives, as the host sees them in bits 2:0
    typedef struct packed {
        logic ack;
        logic bsy;
        logic tx;
    } core_flags_t;

    function automatic logic [15:0] cap_len(input logic [15:0] v);
        return (v > LEN_CAP) ? LEN_CAP : v;
    endfunction

endpackage

// File: rtl/mbx_handshake.sv
`timescale 1ns/1ps
module mbx_handshake
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        core_ctl_we,
    input  logic [2:0]  core_ctl,      // {ack, bsy, tx}
    input  logic        host_flag_we,
    input  logic [3:0]  host_flag,     // {rxp, ack, bsy, rx}
    output core_flags_t cfl,
    output host_flags_t hfl
);

    logic core_set_tx, core_ack, host_set_rx, host_ack;

    assign core_set_tx = core_ctl_we  & core_ctl[0];
    assign core_ack    = core_ctl_we  & core_ctl[2];
    assign host_set_rx = host_flag_we & host_flag[0];
    assign host_ack    = host_flag_we & host_flag[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfl <= '0;
            hfl <= '0;
        end else begin
            cfl.ack <= core_ack;
            hfl.ack <= host_ack;
            if (core_ctl_we)
                cfl.bsy <= core_ctl[1];
            if (host_flag_we) begin
                hfl.bsy <= host_flag[1];
                hfl.rxp <= host_flag[3];
            end
            if (core_set_tx)
                cfl.tx <= 1'b1;
            else if (host_ack)
                cfl.tx <= 1'b0;
            if (host_set_rx)
                hfl.rx <= 1'b1;
            else if (core_ack)
                hfl.rx <= 1'b0;
        end
    end

endmodule

// File: rtl/mbx_cfg.sv
`timescale 1ns/1ps
module mbx_cfg
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        c_we,
    input  logic [7:0]  c_off,
    input  logic [7:0]  c_wd,
    input  logic        h_we,
    input  logic [7:0]  h_off,
    input  logic [7:0]  h_wd,
    input  logic        host_bsy,
    output mbx_mode_e   mode,
    output logic [15:0] mtu,
    output logic [15:0] mru,
    output logic [31:0] ptr,
    output logic [15:0] tx_size,
    output logic [15:0] rx_size,
    output logic [7:0]  tx_byte,
    output logic [7:0]  rx_byte,
    output logic        ovr
);

    logic len_ok, wide_ptr, drop_byte;

    assign len_ok    = (mode != MODE_BYTE);
    assign wide_ptr  = mode[1];
    assign drop_byte = (mode == MODE_BYTE) && host_bsy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_BYTE;
            mtu     <= '0;
            mru     <= '0;
            ptr     <= '0;
            tx_size <= '0;
            rx_size <= '0;
            tx_byte <= '0;
            rx_byte <= '0;
            ovr     <= 1'b0;
        end else begin
            if (c_we) begin
                case (c_off)
                    C_CTRL: begin
                        mode <= mbx_mode_e'(c_wd[7:6]);
                        if (c_wd[4]) ovr <= 1'b0;
                    end
                    C_MTU_H:  if (len_ok) mtu <= cap_len({c_wd, mtu[7:0]});
                    C_MTU_L:  if (len_ok) mtu <= cap_len({mtu[15:8], c_wd});
                    C_MRU_H:  if (len_ok) mru <= cap_len({c_wd, mru[7:0]});
                    C_MRU_L:  if (len_ok) mru <= cap_len({mru[15:8], c_wd});
                    C_PTR_H:  ptr[15:8]  <= c_wd;
                    C_PTR_L:  ptr[7:0]   <= c_wd;
                    C_PTRX_H: if (wide_ptr) ptr[31:24] <= c_wd;
                    C_PTRX_L: if (wide_ptr) ptr[23:16] <= c_wd;
                    C_SIZE_H: tx_size[15:8] <= c_wd;
                    C_SIZE_L: tx_size[7:0]  <= c_wd;
                    C_BYTE: begin
                        if (drop_byte) ovr <= 1'b1;
                        else           tx_byte <= c_wd;
                    end
                    default: ;
                endcase
            end
            if (h_we) begin
                case (h_off)
                    H_BYTE:   rx_byte       <= h_wd;
                    H_SIZE_H: rx_size[15:8] <= h_wd;
                    H_SIZE_L: rx_size[7:0]  <= h_wd;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mbx_buf.sv
`timescale 1ns/1ps
module mbx_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_idx,
    input  logic [7:0]    a_wd,
    output logic [7:0]    a_rd,
    input  logic          b_we,
    input  logic [AW-1:0] b_idx,
    input  logic [7:0]    b_wd,
    output logic [7:0]    b_rd
);

    logic [7:0] mem [DEPTH];
    logic       b_blocked;

    // port a (core) keeps the byte when both write one location
    assign b_blocked = a_we && (a_idx == b_idx);

    always_ff @(posedge clk) begin
        if (b_we && !b_blocked)
            mem[b_idx] <= b_wd;
        if (a_we)
            mem[a_idx] <= a_wd;
    end

    assign a_rd = mem[a_idx];
    assign b_rd = mem[b_idx];

endmodule

// File: rtl/pkt_mailbox.sv
`timescale 1ns/1ps
module pkt_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUF_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic              c_wr,
    input  logic              c_rd,
    input  logic [7:0]        c_wdata,
    output logic [7:0]        c_rdata,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [7:0]        h_wdata,
    output logic [7:0]        h_rdata
);

    localparam int              BUF_AW  = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
    localparam logic [ADDR_W:0] BUF_ORG = (ADDR_W+1)'(RAM_BASE);
    localparam logic [ADDR_W:0] BUF_LEN = (ADDR_W+1)'(BUF_BYTES);

    mbx_mode_e   mode;
    core_flags_t cfl;
    host_flags_t hfl;
    logic        tx_pend, rx_flag, ovr;
    logic [15:0] mtu, mru, tx_size, rx_size;
    logic [31:0] ptr;
    logic [7:0]  tx_byte, rx_byte;

    // ---------------- address decode ----------------
    logic            c_win, h_win;
    logic [7:0]      c_lo, h_lo;
    logic [ADDR_W:0] c_diff, h_diff;
    logic            c_in_buf, h_in_buf;
    logic            c_buf_ok, c_buf_we, h_buf_we;
    logic [7:0]      c_buf_q, h_buf_q;

    assign c_win = (c_addr[ADDR_W-1:8] == '0);
    assign h_win = (h_addr[ADDR_W-1:8] == '0);
    assign c_lo  = c_addr[7:0];
    assign h_lo  = h_addr[7:0];

    assign c_diff   = {1'b0, c_addr} - BUF_ORG;
    assign h_diff   = {1'b0, h_addr} - BUF_ORG;
    assign c_in_buf = !c_diff[ADDR_W] && (c_diff < BUF_LEN);
    assign h_in_buf = !h_diff[ADDR_W] && (h_diff < BUF_LEN);
    assign c_buf_ok = c_in_buf && (mode == MODE_MAP32);
    assign c_buf_we = c_wr && c_buf_ok;
    assign h_buf_we = h_wr && h_in_buf;

    assign tx_pend = cfl.tx;
    assign rx_flag = hfl.rx;

    // ---------------- sub-blocks ----------------
    mbx_handshake u_hs (
        .clk          (clk),
        .rst          (rst),
        .core_ctl_we  (c_wr && c_win && (c_lo == C_CTRL)),
        .core_ctl     (c_wdata[2:0]),
        .host_flag_we (h_wr && h_win && (h_lo == H_FLAGS)),
        .host_flag    (h_wdata[3:0]),
        .cfl          (cfl),
        .hfl          (hfl)
    );

    mbx_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .c_we     (c_wr && c_win),
        .c_off    (c_lo),
        .c_wd     (c_wdata),
        .h_we     (h_wr && h_win),
        .h_off    (h_lo),
        .h_wd     (h_wdata),
        .host_bsy (hfl.bsy),
        .mode     (mode),
        .mtu      (mtu),
        .mru      (mru),
        .ptr      (ptr),
        .tx_size  (tx_size),
        .rx_size  (rx_size),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .ovr      (ovr)
    );

    mbx_buf #(.DEPTH(BUF_BYTES), .AW(BUF_AW)) u_buf (
        .clk   (clk),
        .a_we  (c_buf_we),
        .a_idx (c_diff[BUF_AW-1:0]),
        .a_wd  (c_wdata),
        .a_rd  (c_buf_q),
        .b_we  (h_buf_we),
        .b_idx (h_diff[BUF_AW-1:0]),
        .b_wd  (h_wdata),
        .b_rd  (h_buf_q)
    );

    // ---------------- read muxes ----------------
    logic [7:0] c_rd_nx, h_rd_nx;

    always_comb begin
        c_rd_nx = '0;
        if (c_win) begin
            case (c_lo)
                C_STATUS: c_rd_nx = {mode, 1'b0, ovr, hfl};
                C_MTU_H:  c_rd_nx = mtu[15:8];
                C_MTU_L:  c_rd_nx = mtu[7:0];
                C_MRU_H:  c_rd_nx = mru[15:8];
                C_MRU_L:  c_rd_nx = mru[7:0];
                C_PTR_H:  c_rd_nx = ptr[15:8];
                C_PTR_L:  c_rd_nx = ptr[7:0];
                C_PTRX_H: c_rd_nx = ptr[31:24];
                C_PTRX_L: c_rd_nx = ptr[23:16];
                C_SIZE_H: c_rd_nx = rx_size[15:8];
                C_SIZE_L: c_rd_nx = rx_size[7:0];
                C_BYTE:   c_rd_nx = rx_byte;
                default:  c_rd_nx = '0;
            endcase
        end else if (c_buf_ok) begin
            c_rd_nx = c_buf_q;
        end
    end

    always_comb begin
        h_rd_nx = '0;
        if (h_win) begin
            case (h_lo)
                H_FLAGS:  h_rd_nx = {mode, 1'b0, ovr, 1'b0, cfl};
                H_BYTE:   h_rd_nx = tx_byte;
                H_SIZE_H: h_rd_nx = tx_size[15:8];
                H_SIZE_L: h_rd_nx = tx_size[7:0];
                default:  h_rd_nx = '0;
            endcase
        end else if (h_in_buf) begin
            h_rd_nx = h_buf_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_rdata <= '0;
            h_rdata <= '0;
        end else begin
            if (c_rd) c_rdata <= c_rd_nx;
            if (h_rd) h_rdata <= h_rd_nx;
        end
    end

endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] c_addr,
    input logic              c_wr,
    input logic              c_rd,
    input logic [7:0]        c_wdata,
    input logic [7:0]        c_rdata,
    input logic [ADDR_W-1:0] h_addr,
    input logic              h_wr,
    input logic [7:0]        h_wdata,
    input logic [1:0]        mode,
    input logic              tx_pend,
    input logic              rx_flag,
    input logic              ovr,
    input logic [15:0]       mtu,
    input logic [15:0]       mru,
    input logic [31:0]       ptr
);

    logic c_ctl_wr, h_flag_wr;
    assign c_ctl_wr  = c_wr && (c_addr == ADDR_W'(1));
    assign h_flag_wr = h_wr && (h_addr == ADDR_W'(0));

    AST_TX_CLEARED_BY_HOST_ACK: assert property (@(posedge clk) disable iff (rst)
        (h_flag_wr && h_wdata[2] && !(c_ctl_wr && c_wdata[0])) |=> !tx_pend); // R2

    AST_RX_CLEARED_BY_CORE_ACK: assert property (@(posedge clk) disable iff (rst)
        (c_ctl_wr && c_wdata[2] && !(h_flag_wr && h_wdata[0])) |=> !rx_flag); // R3

    AST_MODE_FROM_CTRL: assert property (@(posedge clk) disable iff (rst)
        c_ctl_wr |=> (mode == $past(c_wdata[7:6]))); // R5

    AST_LEN_NEVER_ABOVE_CAP: assert property (@(posedge clk) disable iff (rst)
        (mtu <= 16'hFF00) && (mru <= 16'hFF00)); // R6

    AST_LEN_HELD_IN_BYTE_MODE: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00) && c_wr && (c_addr >= ADDR_W'(2)) && (c_addr <= ADDR_W'(5)))
        |=> ($stable(mtu) && $stable(mru))); // R6

    AST_UPPER_PTR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!mode[1] && c_wr && ((c_addr == ADDR_W'(8)) || (c_addr == ADDR_W'(9))))
        |=> $stable(ptr[31:16])); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(c_ctl_wr && c_wdata[4])) |=> ovr); // R10

    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (c_rd && (c_addr >= ADDR_W'(16)) && (c_addr < ADDR_W'(256))) |=> (c_rdata == 8'h00)); // R11

endmodule

bind pkt_mailbox mbx_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pkt_mailbox_tb.sv
`timescale 1ns/1ps
module pkt_mailbox_tb;

    localparam int AW  = 16;
    localparam int BUF = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] c_addr = '0, h_addr = '0;
    logic          c_wr = 1'b0, c_rd = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0]    c_wdata = '0, h_wdata = '0;
    logic [7:0]    c_rdata, h_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pkt_mailbox #(.ADDR_W(AW), .BUF_BYTES(BUF)) u_dut (
        .clk(clk), .rst(rst),
        .c_addr(c_addr), .c_wr(c_wr), .c_rd(c_rd), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata)
    );

    // ---------------- behavioural reference ----------------
    bit [1:0]   m_mode;
    bit         m_tx, m_cbsy, m_cack, m_hrx, m_hbsy, m_hack, m_hrxp, m_ovr;
    bit [15:0]  m_mtu, m_mru, m_txs, m_rxs;
    bit [31:0]  m_ptr;
    bit [7:0]   m_txb, m_rxb;
    bit [7:0]   m_buf [BUF];
    logic [7:0] exp_c, exp_h;

    function automatic bit [15:0] cap(input bit [15:0] v);
        return (v > 16'hFF00) ? 16'hFF00 : v;
    endfunction

    function automatic logic [7:0] cread(input int a);
        case (a)
            0:  return {m_mode, 1'b0, m_ovr, m_hrxp, m_hack, m_hbsy, m_hrx};
            2:  return m_mtu[15:8];
            3:  return m_mtu[7:0];
            4:  return m_mru[15:8];
            5:  return m_mru[7:0];
            6:  return m_ptr[15:8];
            7:  return m_ptr[7:0];
            8:  return m_ptr[31:24];
            9:  return m_ptr[23:16];
            10: return m_rxs[15:8];
            11: return m_rxs[7:0];
            15: return m_rxb;
            default: begin
                if (m_mode == 2'b11 && a >= 256 && a < 256 + BUF) return m_buf[a-256];
                return 8'h00;
            end
        endcase
    endfunction

    function automatic logic [7:0] hread(input int a);
        case (a)
            0: return {m_mode, 1'b0, m_ovr, 1'b0, m_cack, m_cbsy, m_tx};
            1: return m_txb;
            2: return m_txs[15:8];
            3: return m_txs[7:0];
            default: begin
                if (a >= 256 && a < 256 + BUF) return m_buf[a-256];
                return 8'h00;
            end
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 0; m_tx = 0; m_cbsy = 0; m_cack = 0; m_hrx = 0; m_hbsy = 0;
        m_hack = 0; m_hrxp = 0; m_ovr = 0; m_mtu = 0; m_mru = 0; m_txs = 0;
        m_rxs = 0; m_ptr = 0; m_txb = 0; m_rxb = 0; exp_c = 0; exp_h = 0;
    endtask

    task automatic model_step();
        int ca = int'(c_addr);
        int ha = int'(h_addr);
        bit cctl = c_wr && ca == 1;
        bit hfl  = h_wr && ha == 0;
        bit core_set = cctl && c_wdata[0];
        bit core_ack = cctl && c_wdata[2];
        bit host_set = hfl && h_wdata[0];
        bit host_ack = hfl && h_wdata[2];
        bit [1:0] om = m_mode;
        bit ob = m_hbsy;
        if (c_rd) exp_c = cread(ca);
        if (h_rd) exp_h = hread(ha);
        m_tx  = core_set ? 1'b1 : (host_ack ? 1'b0 : m_tx);
        m_hrx = host_set ? 1'b1 : (core_ack ? 1'b0 : m_hrx);
        m_cack = core_ack;
        m_hack = host_ack;
        if (hfl) begin m_hbsy = h_wdata[1]; m_hrxp = h_wdata[3]; end
        if (h_wr) begin
            case (ha)
                1: m_rxb = h_wdata;
                2: m_rxs[15:8] = h_wdata;
                3: m_rxs[7:0] = h_wdata;
                default: if (ha >= 256 && ha < 256 + BUF) m_buf[ha-256] = h_wdata;
            endcase
        end
        if (c_wr) begin
            case (ca)
                1: begin
                    m_mode = c_wdata[7:6];
                    m_cbsy = c_wdata[1];
                    if (c_wdata[4]) m_ovr = 0;
                end
                2: if (om != 0) m_mtu = cap({c_wdata, m_mtu[7:0]});
                3: if (om != 0) m_mtu = cap({m_mtu[15:8], c_wdata});
                4: if (om != 0) m_mru = cap({c_wdata, m_mru[7:0]});
                5: if (om != 0) m_mru = cap({m_mru[15:8], c_wdata});
                6: m_ptr[15:8] = c_wdata;
                7: m_ptr[7:0] = c_wdata;
                8: if (om[1]) m_ptr[31:24] = c_wdata;
                9: if (om[1]) m_ptr[23:16] = c_wdata;
                10: m_txs[15:8] = c_wdata;
                11: m_txs[7:0] = c_wdata;
                15: if (om == 0 && ob) m_ovr = 1; else m_txb = c_wdata;
                default: if (om == 2'b11 && ca >= 256 && ca < 256 + BUF) m_buf[ca-256] = c_wdata;
            endcase
        end
    endtask

    // ---------------- checking ----------------
    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag, input string side);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s rdata: actual=%02h expected=%02h", tag, side, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check8(c_rdata, exp_c, tag, "core");
        check8(h_rdata, exp_h, tag, "host");
        c_wr = 0; c_rd = 0; h_wr = 0; h_rd = 0;
    endtask

    task automatic cw(input int a, input int d, input string tag);
        c_addr = AW'(a); c_wdata = 8'(d); c_wr = 1; cyc(tag);
    endtask
    task automatic cr(input int a, input string tag);
        c_addr = AW'(a); c_rd = 1; cyc(tag);
    endtask
    task automatic hw(input int a, input int d, input string tag);
        h_addr = AW'(a); h_wdata = 8'(d); h_wr = 1; cyc(tag);
    endtask
    task automatic hr(input int a, input string tag);
        h_addr = AW'(a); h_rd = 1; cyc(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R13 watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check8(c_rdata, 8'h00, "R1", "core");
        check8(h_rdata, 8'h00, "R1", "host");
        cr(0, "R1"); hr(0, "R1"); cr(2, "R1"); cr(8'h0A, "R1");

        // R2: core send flag and host acknowledge
        cw(1, 8'h01, "R2"); hr(0, "R2");
        cyc("R13");                     // no strobe: read data holds
        hw(0, 8'h04, "R2"); cr(0, "R2"); cr(0, "R2"); hr(0, "R2");
        // same-cycle set and clear: set wins
        c_addr = 1; c_wdata = 8'h01; c_wr = 1; h_addr = 0; h_wdata = 8'h04; h_wr = 1; cyc("R2");
        hr(0, "R2"); hw(0, 8'h04, "R2"); hr(0, "R2");

        // R3: host new-data flag and core acknowledge
        hw(0, 8'h01, "R3"); cr(0, "R3");
        cw(1, 8'h04, "R3"); hr(0, "R3"); hr(0, "R3"); cr(0, "R3");
        c_addr = 1; c_wdata = 8'h04; c_wr = 1; h_addr = 0; h_wdata = 8'h01; h_wr = 1; cyc("R3");
        cr(0, "R3"); cw(1, 8'h04, "R3"); cr(0, "R3");

        // R4: busy and in-progress levels
        hw(0, 8'h0A, "R4"); cr(0, "R4");
        cw(1, 8'h02, "R4"); hr(0, "R4");
        hw(0, 8'h00, "R4"); cw(1, 8'h00, "R4"); cr(0, "R4"); hr(0, "R4");

        // R5: mode encodings
        for (int m = 0; m < 4; m++) begin
            cw(1, m << 6, "R5"); cr(0, "R5"); hr(0, "R5");
        end

        // R6: length registers, saturation, byte-mode ignore
        cw(1, 8'h40, "R6");
        cw(2, 8'h12, "R6"); cw(3, 8'h34, "R6"); cr(2, "R6"); cr(3, "R6");
        cw(2, 8'hFF, "R6"); cw(3, 8'h10, "R6"); cr(2, "R6"); cr(3, "R6");
        cw(5, 8'hFF, "R6"); cw(4, 8'hFF, "R6"); cr(4, "R6"); cr(5, "R6");
        cw(1, 8'h00, "R6"); cw(2, 8'h55, "R6"); cw(5, 8'h01, "R6");
        cr(2, "R6"); cr(3, "R6"); cr(5, "R6");

        // R7: pointer halves
        cw(1, 8'h40, "R7");
        cw(6, 8'hAB, "R7"); cw(7, 8'hCD, "R7"); cw(8, 8'h11, "R7"); cw(9, 8'h22, "R7");
        cr(6, "R7"); cr(7, "R7"); cr(8, "R7"); cr(9, "R7");
        cw(1, 8'h80, "R7"); cw(8, 8'h33, "R7"); cw(9, 8'h44, "R7");
        cr(8, "R7"); cr(9, "R7");

        // R8: size in both directions
        cw(8'h0A, 8'h05, "R8"); cw(8'h0B, 8'hDC, "R8"); hr(2, "R8"); hr(3, "R8");
        hw(2, 8'h02, "R8"); hw(3, 8'h40, "R8"); cr(8'h0A, "R8"); cr(8'h0B, "R8");

        // R9: byte port both ways (not byte mode, host busy ignored)
        cw(1, 8'h40, "R9"); hw(0, 8'h02, "R9");
        cw(15, 8'hA5, "R9"); hr(1, "R9");
        hw(1, 8'h3C, "R9"); cr(15, "R9");

        // R10: drop in byte mode while host busy, sticky overrun
        cw(1, 8'h00, "R10"); cw(15, 8'h77, "R10"); hr(1, "R10"); cr(0, "R10"); hr(0, "R10");
        hw(0, 8'h00, "R10"); cw(15, 8'h66, "R10"); hr(1, "R10"); cr(0, "R10");
        cw(1, 8'h10, "R10"); cr(0, "R10"); hr(0, "R10");

        // R11: reserved offsets
        cw(8'h10, 8'hFF, "R11"); cw(8'h0C, 8'hFF, "R11"); cw(0, 8'hFF, "R11");
        cr(8'h10, "R11"); cr(8'hFF, "R11"); cr(8'h0C, "R11"); cr(8'h0E, "R11");
        cr(1, "R11"); cr(0, "R11"); hr(0, "R11");

        // R12: shared RAM window
        cw(1, 8'hC0, "R12");
        for (int i = 0; i < BUF; i++) cw(256 + i, i * 7 + 1, "R12");
        for (int i = 0; i < BUF; i++) hr(256 + i, "R12");
        hw(256 + 4, 8'h99, "R12"); cr(256 + 4, "R12"); cr(256 + BUF - 1, "R12");
        cr(256 + BUF, "R12"); hr(256 + BUF, "R12");
        c_addr = AW'(257); c_wdata = 8'h5A; c_wr = 1; h_addr = AW'(257); h_wdata = 8'hA5; h_wr = 1; cyc("R12");
        cr(257, "R12"); hr(257, "R12");
        cw(1, 8'h80, "R12"); cw(256 + 5, 8'hEE, "R12"); cr(256 + 5, "R12"); hr(256 + 5, "R12");
        hw(256 + 6, 8'h42, "R12"); hr(256 + 6, "R12"); cr(256 + 6, "R12");
        cw(1, 8'hC0, "R12"); cr(256 + 6, "R12");

        done = 1;
        finish_run();
    end

endmodule